// File: doc/BRIEF.md
# Timer Event Interrupt Status Controller

This block turns two timer event sources into an interrupt request and a DMA event pulse. The first source is a period-match strobe, raised by the counter logic when the count reaches the programmed period. The second is a capture strobe, which counts only while the counter logic reports that capture mode is on. The block does no counting and stores no captured values. It qualifies the two strobes and keeps a record of the events that were let through.

Software sees one small control/status word. It holds an enable bit and a sticky status bit for each source. Writing a word loads the enable bits. A 1 written to a status bit clears that bit, and a 0 leaves it alone. The whole feature sits under a global enable input. While that input is low, both status bits are forced to zero and neither output can assert.

Top module: `timer_evt_irq_ctrl`

## Requirements
- R1: After synchronous active-low reset, both enables and both status bits are 0, `irq_o` is 0 and `dma_evt_o` is 0.
- R2: A write (`csr_we`=1) loads `csr_wdata[0]` into the period enable and `csr_wdata[1]` into the capture enable at the clock edge. `csr_rdata` reads {capture status, period status, capture enable, period enable} in bits 3..0.
- R3: With global enable and period enable both set, `per_match` high at an edge sets the period status bit (bit 2).
- R4: With global enable and capture enable both set, the capture status bit (bit 3) sets only when `cap_strobe` and `cap_mode` are both high at the edge. A `cap_strobe` while `cap_mode` is low leaves the bit unchanged.
- R5: A source whose enable bit is 0 never sets its status bit and never causes a DMA pulse.
- R6: Writing 1 to status bit 2 or 3 clears that bit at the edge. Writing 0 to it leaves it unchanged.
- R7: If a qualified event and a write-1-clear reach the same status bit at the same edge, the bit ends up set.
- R8: While global enable is high, `irq_o` is the OR of the two status bits, and it stays high until software clears both.
- R9: `dma_evt_o` is high for exactly the one cycle after each edge at which at least one qualified event occurred.
- R10: While `glb_en` is low, `irq_o` and `dma_evt_o` are low in that same cycle, and both status bits are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable for the extended event feature |
| per_match | input | 1 | Strobe: counter equals period |
| cap_strobe | input | 1 | Strobe: external capture event |
| cap_mode | input | 1 | Capture mode is on |
| csr_we | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 4 | Write data: enables in [1:0], write-1-clear status in [3:2] |
| csr_rdata | output | 4 | Read data: {cap status, per status, cap enable, per enable} |
| irq_o | output | 1 | Level interrupt request |
| dma_evt_o | output | 1 | One-cycle DMA event pulse |

## Verification
The bench builds the block with the package defaults: two sources and a four-bit control/status word. This gives only sixteen register states plus a handful of strobe and write inputs. A few hundred random cycles with a fixed seed therefore reach every combination of enable, status, event and clear, including the same-edge set/clear conflict and global-enable drops while status is pending. Directed steps pin down the reset values, the capture-mode gating and the same-cycle silencing of the outputs.

// File: rtl/tevt_pkg.sv
// Package: shared sizes and source indices for the timer event controller.
// Assumes exactly one period source and one capture source.
package tevt_pkg;
    localparam int SRC_N  = 2;
    localparam int CSR_W  = 2 * SRC_N;
    localparam int EN_LSB = 0;
    localparam int ST_LSB = SRC_N;

    typedef enum int {
        SRC_PERIOD  = 0,
        SRC_CAPTURE = 1
    } src_idx_e;
endpackage

// File: rtl/tevt_csr.sv
// Module: tevt_csr
// Holds the per-source enable bits, decodes the write-1-clear field and
// assembles the read word. Assumes the status bits are stored elsewhere
// and returned through st_i.
module tevt_csr
    import tevt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CSR_W-1:0] wdata_i,
    input  logic [SRC_N-1:0] st_i,
    output logic [SRC_N-1:0] en_o,
    output logic [SRC_N-1:0] clr_o,
    output logic [CSR_W-1:0] rdata_o
);
    logic [SRC_N-1:0] en_q;

    // Load the enable field on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (we_i)
            en_q <= wdata_i[EN_LSB +: SRC_N];
    end

    // Decode the clear requests and build the read word.
    always_comb begin
        clr_o   = we_i ? wdata_i[ST_LSB +: SRC_N] : '0;
        rdata_o = {st_i, en_q};
    end

    assign en_o = en_q;

    // R2
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> en_q == $past(wdata_i[EN_LSB +: SRC_N]));
endmodule

// File: rtl/tevt_qualify.sv
// Module: tevt_qualify
// Qualifies raw source strobes with the global enable and each source's
// enable bit. Assumes the capture strobe is already masked by capture mode.
module tevt_qualify
    import tevt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en_i,
    input  logic [SRC_N-1:0] raw_i,
    input  logic [SRC_N-1:0] en_i,
    output logic [SRC_N-1:0] qual_o
);
    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        // Pass a strobe only when the feature and its source are enabled.
        always_comb qual_o[g] = glb_en_i & en_i[g] & raw_i[g];

        // R5
        qual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[g] |-> !qual_o[g]);
    end
endmodule

// File: rtl/tevt_status_bit.sv
// Module: tevt_status_bit
// One sticky status bit: set by a qualified event, cleared by a write of 1,
// forced to 0 while the global enable is low. A set beats a clear.
module tevt_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_en_i,
    input  logic set_i,
    input  logic clr_i,
    output logic st_o
);
    logic st_q;

    // Update the sticky bit with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !glb_en_i)
            st_q <= 1'b0;
        else if (set_i)
            st_q <= 1'b1;
        else if (clr_i)
            st_q <= 1'b0;
    end

    assign st_o = st_q;

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && set_i) |=> st_q);
    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && clr_i && !set_i) |=> !st_q);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && !clr_i && !set_i) |=> $stable(st_q));
    // R10
    glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> !st_q);
endmodule

// File: rtl/tevt_req_out.sv
// Module: tevt_req_out
// Drives the level interrupt from the status bits and a one-cycle DMA pulse
// from the qualified events. Both outputs are silenced by the global enable.
module tevt_req_out
    import tevt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en_i,
    input  logic [SRC_N-1:0] qual_i,
    input  logic [SRC_N-1:0] st_i,
    output logic             irq_o,
    output logic             dma_o
);
    logic dma_q;

    // Register a pulse for every edge that saw a qualified event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_q <= 1'b0;
        else
            dma_q <= |qual_i;
    end

    // Gate both requests with the global enable.
    always_comb begin
        irq_o = glb_en_i & (|st_i);
        dma_o = glb_en_i & dma_q;
    end

    // R9
    dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_q |-> $past(|qual_i));
    // R9
    dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_q && !(|qual_i)) |=> !dma_q);
    // R10
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |-> (!irq_o && !dma_o));
endmodule

// File: rtl/timer_evt_irq_ctrl.sv
// Module: timer_evt_irq_ctrl (top)
// Turns a period-match strobe and a capture strobe into an interrupt level
// and a DMA pulse, with a per-source enable and sticky write-1-clear status.
// Assumes the strobes are synchronous to clk and one cycle wide per event.
module timer_evt_irq_ctrl
    import tevt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic             per_match,
    input  logic             cap_strobe,
    input  logic             cap_mode,
    input  logic             csr_we,
    input  logic [CSR_W-1:0] csr_wdata,
    output logic [CSR_W-1:0] csr_rdata,
    output logic             irq_o,
    output logic             dma_evt_o
);
    logic [SRC_N-1:0] raw;
    logic [SRC_N-1:0] en;
    logic [SRC_N-1:0] clr;
    logic [SRC_N-1:0] qual;
    logic [SRC_N-1:0] st;

    // Map the counter-side strobes onto source positions.
    always_comb begin
        raw              = '0;
        raw[SRC_PERIOD]  = per_match;
        raw[SRC_CAPTURE] = cap_strobe & cap_mode;
    end

    tevt_csr u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (csr_we),
        .wdata_i (csr_wdata),
        .st_i    (st),
        .en_o    (en),
        .clr_o   (clr),
        .rdata_o (csr_rdata)
    );

    tevt_qualify u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_en_i (glb_en),
        .raw_i    (raw),
        .en_i     (en),
        .qual_o   (qual)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_st
        tevt_status_bit u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .glb_en_i (glb_en),
            .set_i    (qual[g]),
            .clr_i    (clr[g]),
            .st_o     (st[g])
        );
    end

    tevt_req_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_en_i (glb_en),
        .qual_i   (qual),
        .st_i     (st),
        .irq_o    (irq_o),
        .dma_o    (dma_evt_o)
    );

    // R4
    cap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && !cap_mode && !st[SRC_CAPTURE]) |=> !st[SRC_CAPTURE]);
    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && (|csr_rdata[CSR_W-1:SRC_N])) |-> irq_o);
endmodule

// File: tb/timer_evt_irq_ctrl_test.sv
module timer_evt_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0, per_match = 1'b0, cap_strobe = 1'b0, cap_mode = 1'b0;
    logic       csr_we = 1'b0;
    logic [3:0] csr_wdata = 4'h0;
    logic [3:0] csr_rdata;
    logic       irq_o, dma_evt_o;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_en = 2'b00, m_st = 2'b00;
    logic       m_dma = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    timer_evt_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .per_match(per_match),
        .cap_strobe(cap_strobe), .cap_mode(cap_mode), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_o(irq_o),
        .dma_evt_o(dma_evt_o)
    );

    // Expected read word and outputs from the model state and current glb_en.
    function automatic logic [5:0] exp_view(logic g, logic [1:0] en, logic [1:0] st, logic d);
        return {g & d, g & (|st), st, en};
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%b exp=%b (dma,irq,rdata)", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check after the rise.
    task automatic step(string tag, logic g, logic pm, logic cs, logic cm, logic we, logic [3:0] wd);
        logic [1:0] q;
        logic [1:0] st_n;
        @(negedge clk);
        glb_en = g; per_match = pm; cap_strobe = cs; cap_mode = cm;
        csr_we = we; csr_wdata = wd;
        q[0] = g & m_en[0] & pm;
        q[1] = g & m_en[1] & cs & cm;
        for (int i = 0; i < 2; i++)
            st_n[i] = g & (q[i] | (m_st[i] & ~(we & wd[2+i])));
        @(posedge clk);
        m_st = st_n;
        m_dma = |q;
        if (we) m_en = wd[1:0];
        #1;
        check(tag, {dma_evt_o, irq_o, csr_rdata}, exp_view(glb_en, m_en, m_st, m_dma));
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {dma_evt_o, irq_o, csr_rdata}, 6'b0);
        @(negedge clk); rst_n = 1'b1;
        // R2 enable load and readback
        step("R2 load enables", 1, 0, 0, 0, 1, 4'b0011);
        step("R2 load period only", 1, 0, 0, 0, 1, 4'b0001);
        // R5 disabled capture source ignored
        step("R5 capture disabled", 1, 0, 1, 1, 0, 4'h0);
        // R3 period event sets status, R9 dma pulse
        step("R3 period set", 1, 1, 0, 0, 0, 4'h0);
        step("R9 dma one cycle", 1, 0, 0, 0, 0, 4'h0);
        step("R8 irq holds", 1, 0, 0, 0, 0, 4'h0);
        // R6 write 0 keeps, write 1 clears
        step("R6 write0 keeps", 1, 0, 0, 0, 1, 4'b0011);
        step("R6 write1 clears", 1, 0, 0, 0, 1, 4'b0111);
        // R4 capture needs capture mode
        step("R4 strobe no mode", 1, 0, 1, 0, 0, 4'h0);
        step("R4 strobe with mode", 1, 0, 1, 1, 0, 4'h0);
        // R7 set wins over clear
        step("R7 set vs clear", 1, 0, 1, 1, 1, 4'b1011);
        step("R8 irq after clear", 1, 0, 0, 0, 1, 4'b1011);
        // R10 same-cycle silencing while status pending
        step("R10 arm", 1, 1, 0, 0, 0, 4'h0);
        @(negedge clk); glb_en = 1'b0; per_match = 1'b0; csr_we = 1'b0; #1;
        check("R10 same cycle quiet", {dma_evt_o, irq_o}, 2'b00);
        step("R10 status dropped", 0, 1, 1, 1, 0, 4'h0);
        step("R10 events ignored", 0, 1, 1, 1, 0, 4'h0);
        // Random mix covering R3..R10
        for (int n = 0; n < 600; n++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step("R3/R4/R6/R7/R9 random", ($urandom % 8) != 0, r[0], r[1], r[2],
                 ($urandom % 4) == 0, r[7:4]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule